// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block is one data-watchpoint comparator inside a processor debug unit. Software programs two registers through a simple register port. The first is a 32-bit watch value that holds the target address. The second is a control word that selects how an access must look to count as a hit. The unit observes every data access that the core presents and raises a single-cycle `hit` pulse when one access meets every programmed condition.

A match needs several things at once. The unit must be enabled. The access bytes must fall inside the watched window. The access kind and the access privilege must both be allowed. When linking is enabled, a selected context-ID breakpoint flag must also be set. The window is set in one of two ways. One way uses eight byte lanes around the watch value. The other way uses a power-of-two range that removes low address bits from the compare.

Top module: `dwpt_match_unit`

## Requirements
- R1: After a synchronous reset, the watch value and the control word both read 0, and `hit` is 0.
- R2: `reg_sel`=0 selects the watch value and `reg_sel`=1 selects the control word. `reg_rdata` returns the selected register. A write stores all 32 bits of the watch value. For the control word, only bits 28:24, 20:16 and 12:0 are kept; every other bit reads 0, so writing all ones reads back 0x1F1F1FFF. A write changes the register at the clock edge. An access presented in the same cycle as the write is judged with the old contents, and an access in the next cycle uses the new contents.
- R3: When control bit 0 is 0, `hit` is never asserted.
- R4: The range size k sits in control bits 28:24. With k=0, the select field in control bits 12:5 picks byte lanes. Lane j (0..3) is byte (value & ~3)+j, and lane j (4..7) is byte (value & ~7)+j. A select field of all zeros never hits.
- R5: With k from 3 to 31, the lane select field is ignored. An accessed byte b matches when b and the watch value agree on every bit from bit k upward. Codes k=1 and k=2 never hit.
- R6: `acc_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The access covers bytes `acc_addr` through `acc_addr`+size−1, with wrap-around at 32 bits. The address condition holds when any covered byte matches.
- R7: `acc_kind` codes are 0=load, 1=store, 2=swap, 3=load-exclusive and 4=store-exclusive; codes 5 to 7 are neither a load nor a store. Loads are codes 0, 2 and 3; stores are codes 1, 2 and 4. Control bits 4:3 set the access-type filter: 01 passes loads, 10 passes stores, 11 passes both, and 00 never hits.
- R8: `acc_priv`=1 marks a privileged access. Control bits 2:1 set the privilege filter: 01 passes privileged accesses only, 10 passes unprivileged accesses only, 11 passes all, and 00 never hits.
- R9: When control bit 20 is 1, a hit also needs `ctx_match[n]` to be 1, where n is control bits 19:16. When bit 20 is 0, `ctx_match` has no effect.
- R10: `hit` is registered. It is 1 in the cycle after a qualifying access with `acc_valid`=1, and it is 0 after any cycle in which `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 watch value, 1 control word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | Access size code (1, 2, 4 or 8 bytes) |
| acc_kind | input | 3 | Access kind code |
| acc_priv | input | 1 | 1 for a privileged access |
| ctx_match | input | 16 | Context-ID match flags from the breakpoint units |
| hit | output | 1 | Registered one-cycle watchpoint hit |

## Verification
The bench sweeps several cases:
- every single lane and several mixed lane patterns, with the watch value both word-aligned and doubleword-aligned, against accesses of every size that start before, inside and past the window;
- every range size, each probed with an address that differs from the watch value in one bit at a time;
- every combination of the access-type filter, the privilege filter, the access kind and the privilege level;
- every link selector against single-flag and all-zero flag patterns.

These sweeps catch specific faults:
- A design that aligned the upper lanes to the word instead of the doubleword would hit on the wrong bytes when bit 2 of the watch value is set.
- A design that checked only the first byte would miss accesses that straddle into the window.
- Off-by-one errors in the range mask, or treating codes 1 and 2 as valid, would flip the result in the one-bit probes.

Further tests cover timing and the filters:
- An access in the same cycle as a control write must use the old contents.
- A `hit` that lingers after `acc_valid` drops is reported.
- Swap accesses must pass both the load filter and the store filter.
- Store-exclusive accesses must never pass the load filter.

// File: rtl/dwpt_pkg.sv
package dwpt_pkg;

    localparam int ADDR_W    = 32;
    localparam int REG_W     = 32;
    localparam int LANES     = 8;
    localparam int MSIZE_W   = 5;
    localparam int LINKSEL_W = 4;
    localparam int KIND_W    = 3;

    typedef enum logic [KIND_W-1:0] {
        ACC_LOAD  = 3'd0,
        ACC_STORE = 3'd1,
        ACC_SWAP  = 3'd2,
        ACC_LDEX  = 3'd3,
        ACC_STEX  = 3'd4
    } acc_kind_e;

    typedef struct packed {
        logic [MSIZE_W-1:0]   msize;
        logic                 link_en;
        logic [LINKSEL_W-1:0] link_sel;
        logic [LANES-1:0]     lanes;
        logic [1:0]           type_sel;
        logic [1:0]           priv_sel;
        logic                 enable;
    } wp_ctrl_t;

    function automatic wp_ctrl_t ctrl_from_word(logic [REG_W-1:0] w);
        wp_ctrl_t c;
        c.msize    = w[28:24];
        c.link_en  = w[20];
        c.link_sel = w[19:16];
        c.lanes    = w[12:5];
        c.type_sel = w[4:3];
        c.priv_sel = w[2:1];
        c.enable   = w[0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(wp_ctrl_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[28:24] = c.msize;
        w[20]    = c.link_en;
        w[19:16] = c.link_sel;
        w[12:5]  = c.lanes;
        w[4:3]   = c.type_sel;
        w[2:1]   = c.priv_sel;
        w[0]     = c.enable;
        return w;
    endfunction

    // Bits kept in the ranged compare: everything at or above bit k.
    function automatic logic [ADDR_W-1:0] keep_bits(logic [MSIZE_W-1:0] k);
        return ~((ADDR_W'(1) << k) - ADDR_W'(1));
    endfunction

    // Range codes 1 and 2 are reserved.
    function automatic logic msize_legal(logic [MSIZE_W-1:0] k);
        return (k == '0) || (k >= MSIZE_W'(3));
    endfunction

    function automatic logic kind_reads(logic [KIND_W-1:0] k);
        return (k == ACC_LOAD) || (k == ACC_SWAP) || (k == ACC_LDEX);
    endfunction

    function automatic logic kind_writes(logic [KIND_W-1:0] k);
        return (k == ACC_STORE) || (k == ACC_SWAP) || (k == ACC_STEX);
    endfunction

endpackage

// File: rtl/dwpt_regs.sv
module dwpt_regs
    import dwpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] value_q,
    output wp_ctrl_t          ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            ctrl_q  <= '0;
        end else if (reg_wr) begin
            if (reg_sel) begin
                ctrl_q <= ctrl_from_word(reg_wdata);
            end else begin
                value_q <= reg_wdata[ADDR_W-1:0];
            end
        end
    end

    always_comb begin
        if (reg_sel) begin
            reg_rdata = ctrl_to_word(ctrl_q);
        end else begin
            reg_rdata = REG_W'(value_q);
        end
    end

endmodule

// File: rtl/dwpt_addr_cmp.sv
module dwpt_addr_cmp
    import dwpt_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic [ADDR_W-1:0] value,
    input  wp_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output logic              addr_ok
);

    localparam int NB_W = $clog2(MAX_BYTES + 1);

    logic [NB_W-1:0]   nbytes;
    logic [ADDR_W-1:0] keep;
    logic              ranged;
    logic [MAX_BYTES-1:0] byte_hit;

    assign nbytes = NB_W'(1) << acc_size;
    assign keep   = keep_bits(ctrl.msize);
    assign ranged = (ctrl.msize != '0);

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
        logic [ADDR_W-1:0] baddr;
        logic              covered;
        logic              word_eq;
        logic              dword_eq;
        logic              lane_hit;
        logic              range_hit;

        assign baddr    = acc_addr + ADDR_W'(g);
        assign covered  = (NB_W'(g) < nbytes);
        assign word_eq  = (baddr[ADDR_W-1:2] == value[ADDR_W-1:2]);
        assign dword_eq = (baddr[ADDR_W-1:3] == value[ADDR_W-1:3]);

        always_comb begin
            lane_hit = 1'b0;
            if (word_eq && ctrl.lanes[{1'b0, baddr[1:0]}]) begin
                lane_hit = 1'b1;
            end
            if (dword_eq && baddr[2] && ctrl.lanes[{1'b1, baddr[1:0]}]) begin
                lane_hit = 1'b1;
            end
        end

        assign range_hit = (((baddr ^ value) & keep) == '0);

        assign byte_hit[g] = covered && (ranged ? range_hit : lane_hit);
    end

    assign addr_ok = msize_legal(ctrl.msize) && (|byte_hit);

endmodule

// File: rtl/dwpt_qual.sv
module dwpt_qual
    import dwpt_pkg::*;
#(
    parameter int NUM_BRP = 16
) (
    input  wp_ctrl_t            ctrl,
    input  logic [KIND_W-1:0]   acc_kind,
    input  logic                acc_priv,
    input  logic [NUM_BRP-1:0]  ctx_match,
    output logic                qual_ok
);

    logic rd, wr;
    logic type_ok, priv_ok, link_ok;

    assign rd = kind_reads(acc_kind);
    assign wr = kind_writes(acc_kind);

    always_comb begin
        unique case (ctrl.type_sel)
            2'b01:   type_ok = rd;
            2'b10:   type_ok = wr;
            2'b11:   type_ok = rd | wr;
            default: type_ok = 1'b0;
        endcase
    end

    always_comb begin
        unique case (ctrl.priv_sel)
            2'b01:   priv_ok = acc_priv;
            2'b10:   priv_ok = ~acc_priv;
            2'b11:   priv_ok = 1'b1;
            default: priv_ok = 1'b0;
        endcase
    end

    always_comb begin
        link_ok = 1'b1;
        if (ctrl.link_en) begin
            link_ok = 1'b0;
            for (int i = 0; i < NUM_BRP; i++) begin
                if (ctrl.link_sel == LINKSEL_W'(i)) begin
                    link_ok = ctx_match[i];
                end
            end
        end
    end

    assign qual_ok = ctrl.enable && type_ok && priv_ok && link_ok;

endmodule

// File: rtl/dwpt_match_unit.sv
module dwpt_match_unit
    import dwpt_pkg::*;
#(
    parameter int NUM_BRP   = 16,
    parameter int MAX_BYTES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               acc_valid,
    input  logic [31:0]        acc_addr,
    input  logic [1:0]         acc_size,
    input  logic [2:0]         acc_kind,
    input  logic               acc_priv,
    input  logic [NUM_BRP-1:0] ctx_match,
    output logic               hit
);

    logic [ADDR_W-1:0] value_q;
    wp_ctrl_t          ctrl_q;
    logic              addr_ok;
    logic              qual_ok;

    dwpt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .value_q   (value_q),
        .ctrl_q    (ctrl_q)
    );

    dwpt_addr_cmp #(.MAX_BYTES(MAX_BYTES)) u_addr (
        .value    (value_q),
        .ctrl     (ctrl_q),
        .acc_addr (acc_addr),
        .acc_size (acc_size),
        .addr_ok  (addr_ok)
    );

    dwpt_qual #(.NUM_BRP(NUM_BRP)) u_qual (
        .ctrl      (ctrl_q),
        .acc_kind  (acc_kind),
        .acc_priv  (acc_priv),
        .ctx_match (ctx_match),
        .qual_ok   (qual_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit <= 1'b0;
        end else begin
            hit <= acc_valid && addr_ok && qual_ok;
        end
    end

endmodule

// File: rtl/dwpt_checker.sv
module dwpt_checker
    import dwpt_pkg::*;
#(
    parameter int NUM_BRP = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_valid,
    input logic               acc_priv,
    input logic [NUM_BRP-1:0] ctx_match,
    input wp_ctrl_t           ctrl,
    input logic               hit
);

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !hit);

    p_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> !hit);

    p_no_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.msize == '0 && ctrl.lanes == '0) |=> !hit);

    p_reserved_range_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.msize == 5'd1 || ctrl.msize == 5'd2) |=> !hit);

    p_reserved_type_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.type_sel == 2'b00) |=> !hit);

    p_priv_only_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.priv_sel == 2'b01 && !acc_priv) |=> !hit);

    p_user_only_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.priv_sel == 2'b10 && acc_priv) |=> !hit);

    p_link_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.link_en && !ctx_match[ctrl.link_sel]) |=> !hit);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !hit);

endmodule

bind dwpt_match_unit dwpt_checker #(.NUM_BRP(NUM_BRP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_priv  (acc_priv),
    .ctx_match (ctx_match),
    .ctrl      (ctrl_q),
    .hit       (hit)
);

// File: tb/tb_dwpt_match_unit.sv
`timescale 1ns/1ps
module tb_dwpt_match_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [1:0]  acc_size;
    logic [2:0]  acc_kind;
    logic        acc_priv;
    logic [15:0] ctx_match;
    logic        hit;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    logic [31:0] m_value;
    logic [31:0] m_ctrl;

    always #2 clk = ~clk;

    dwpt_match_unit dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_kind(acc_kind), .acc_priv(acc_priv), .ctx_match(ctx_match),
        .hit(hit)
    );

    // Expected hit, worked out byte by byte from the requirement text.
    function automatic bit model(logic [31:0] v, logic [31:0] c,
                                 logic [31:0] a, logic [1:0] sz,
                                 logic [2:0] kd, logic pr, logic [15:0] cx);
        int k;
        bit ld, st, t_ok, p_ok, l_ok, a_ok;
        logic [31:0] b, base, msk;
        if (c[0] == 1'b0) return 0;
        k  = int'(c[28:24]);
        ld = (kd == 3'd0) || (kd == 3'd2) || (kd == 3'd3);
        st = (kd == 3'd1) || (kd == 3'd2) || (kd == 3'd4);
        case (c[4:3])
            2'd1: t_ok = ld;
            2'd2: t_ok = st;
            2'd3: t_ok = ld || st;
            default: t_ok = 0;
        endcase
        case (c[2:1])
            2'd1: p_ok = pr;
            2'd2: p_ok = !pr;
            2'd3: p_ok = 1;
            default: p_ok = 0;
        endcase
        l_ok = c[20] ? cx[c[19:16]] : 1'b1;
        a_ok = 0;
        for (int i = 0; i < (1 << sz); i++) begin
            b = a + 32'(i);
            if (k == 0) begin
                for (int j = 0; j < 8; j++) begin
                    base = (j < 4) ? (v & 32'hFFFF_FFFC) : (v & 32'hFFFF_FFF8);
                    if (c[5+j] && b == base + 32'(j)) a_ok = 1;
                end
            end else if (k >= 3) begin
                msk = (32'h1 << k) - 32'h1;
                if ((b & ~msk) == (v & ~msk)) a_ok = 1;
            end
        end
        return t_ok && p_ok && l_ok && a_ok;
    endfunction

    task automatic chk(logic [31:0] got, logic [31:0] exp, string req);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(bit sel, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (sel) m_ctrl = d & 32'h1F1F_1FFF; else m_value = d;
    endtask

    task automatic access(logic [31:0] a, logic [1:0] sz, logic [2:0] kd,
                          logic pr, logic [15:0] cx, string req);
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_size = sz; acc_kind = kd;
        acc_priv = pr; ctx_match = cx;
        @(posedge clk); #1;
        chk(32'(hit), 32'(model(m_value, m_ctrl, a, sz, kd, pr, cx)), req);
        @(negedge clk);
        acc_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  bas_set [10];
        logic [31:0] vals [2];
        rst = 1; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        acc_valid = 0; acc_addr = 0; acc_size = 0; acc_kind = 0;
        acc_priv = 0; ctx_match = 0;
        m_value = 0; m_ctrl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        reg_sel = 0; #1; chk(reg_rdata, 32'h0, "R1 value");
        reg_sel = 1; #1; chk(reg_rdata, 32'h0, "R1 ctrl");
        chk(32'(hit), 32'h0, "R1 hit");

        // R2 readback
        wr(0, 32'hDEAD_BEEF);
        reg_sel = 0; #1; chk(reg_rdata, 32'hDEAD_BEEF, "R2 value");
        wr(1, 32'hFFFF_FFFF);
        reg_sel = 1; #1; chk(reg_rdata, 32'h1F1F_1FFF, "R2 ctrl mask");
        wr(1, 32'h0);

        // R2 write timing: same-cycle access sees old control
        wr(0, 32'h0000_2000);
        @(negedge clk);
        reg_wr = 1; reg_sel = 1; reg_wdata = 32'h0000_1FFF;
        acc_valid = 1; acc_addr = 32'h2000; acc_size = 0; acc_kind = 0;
        acc_priv = 1; ctx_match = 0;
        @(posedge clk); #1; chk(32'(hit), 32'h0, "R2 old ctrl used");
        @(negedge clk); reg_wr = 0; m_ctrl = 32'h0000_1FFF;
        @(posedge clk); #1; chk(32'(hit), 32'h1, "R2 new ctrl used");
        @(negedge clk); acc_valid = 0;
        // R10 hit drops once valid is low
        @(posedge clk); #1; chk(32'(hit), 32'h0, "R10 single pulse");

        // R3 enable off
        wr(1, 32'h0000_1FFE);
        access(32'h2000, 0, 0, 1, 0, "R3 disabled");
        access(32'h2001, 3, 2, 0, 0, "R3 disabled");

        // R4 and R6 lane sweep
        bas_set = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40,
                    8'h80, 8'h00, 8'h5A};
        vals = '{32'h1000_0100, 32'h1000_0104};
        foreach (vals[vi]) begin
            wr(0, vals[vi]);
            foreach (bas_set[bi]) begin
                wr(1, {19'h0, bas_set[bi], 5'b11_11_1});
                for (int off = -8; off < 16; off++) begin
                    for (int sz = 0; sz < 4; sz++) begin
                        access(32'h1000_0100 + 32'(off), 2'(sz), 3'd1, 0, 0,
                               "R4 R6 lanes");
                    end
                end
            end
        end

        // R5 range sweep with one-bit probes
        wr(0, 32'h5A5A_5A00);
        for (int k = 0; k < 32; k++) begin
            wr(1, {3'b0, 5'(k), 11'h0, 8'hFF, 5'b11_11_1});
            access(32'h5A5A_5A00, 0, 0, 0, 0, "R5 range exact");
            for (int j = 0; j < 32; j++) begin
                access(32'h5A5A_5A00 ^ (32'h1 << j), 0, 0, 0, 0, "R5 range probe");
            end
        end
        // R6 wrap-around at top of address space
        wr(0, 32'h0000_0000);
        wr(1, {19'h0, 8'h01, 5'b11_11_1});
        access(32'hFFFF_FFFC, 3, 0, 0, 0, "R6 wrap");

        // R7 and R8 qualifier sweep
        wr(0, 32'h0000_3000);
        for (int ls = 0; ls < 4; ls++) begin
            for (int pv = 0; pv < 4; pv++) begin
                wr(1, {19'h0, 8'hFF, 2'(ls), 2'(pv), 1'b1});
                for (int kd = 0; kd < 8; kd++) begin
                    for (int pr = 0; pr < 2; pr++) begin
                        access(32'h3000, 2, 3'(kd), 1'(pr), 0, "R7 R8 qualifiers");
                    end
                end
            end
        end

        // R9 link sweep
        for (int e = 0; e < 2; e++) begin
            for (int n = 0; n < 16; n++) begin
                wr(1, {11'h0, 1'(e), 4'(n), 3'b0, 8'hFF, 5'b11_11_1});
                for (int f = 0; f < 16; f++) begin
                    access(32'h3000, 0, 0, 0, 16'h1 << f, "R9 link");
                end
                access(32'h3000, 0, 0, 0, 16'h0000, "R9 link none");
                access(32'h3000, 0, 0, 0, 16'hFFFF, "R9 link all");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule